// File: doc/BRIEF.md
# Viewpoint Source-Select Sequencer

This block steps an affine-invariant feature pipeline through its sixteen viewpoint passes. For each pass it chooses which of three frames in external memory feeds the scaler datapath: the original image, the fully blurred frame, or the blurred frame already halved in width. It also supplies the scale ratios for that pass and the enables that steer the datapath.

Pass 0 uses the identity transform. The original image goes directly to the feature stage. The same pixel stream also drives the blur filter and the half-width generator, which write the two derived frames to memory. The later passes are independent of one another and each reads one stored frame. A pass takes the half-width frame when its horizontal ratio is at most one half. In that case the scaler receives a doubled horizontal ratio, because the stored frame has already been halved. The datapath reports the end of each pass with a one-cycle `pass_done_i` pulse, and the sequencer then moves to the next index.

Top module: `vp_src_seq`

## Requirements
- R1: After reset the sequencer is idle. The outputs are `vp_idx_o`=0, `busy_o`=0, `all_done_o`=0, and all enables are 0.
- R2: A `start_i` pulse makes the sequencer busy at index 0 on the next cycle. While busy at index 0, `bypass_o`, `blur_wr_en_o` and `half_wr_en_o` are 1, `scaler_en_o` is 0, and `src_sel_o` is 0 (original image).
- R3: While busy, a `pass_done_i` pulse without `start_i` increments `vp_idx_o` by one on the next cycle.
- R4: While busy at indices 1 to 15, `scaler_en_o`=1 and `bypass_o`, `blur_wr_en_o` and `half_wr_en_o` are 0. `src_sel_o` is 1 (full-blur frame) when the sx code is greater than 512, and 2 (half-width frame) otherwise.
- R5: `sx_o` and `sy_o` are unsigned codes with 10 fraction bits (1024 = 1.0). For indices 0 to 15 the sx codes are 1024,1024,882,581,581,882,1024,977,842,637,399,256,399,636,842,977. The sy codes are 1024,512,595,903,903,595,256,268,311,412,655,1024,656,413,311,268.
- R6: `eff_sx_o` equals twice `sx_o` when `src_sel_o` is 2, and equals `sx_o` otherwise.
- R7: `pass_done_i` at index 15 ends the run on the next cycle. After that cycle `busy_o`=0, `all_done_o`=1 and `vp_idx_o`=0, and `all_done_o` stays 1 until the next start.
- R8: A `pass_done_i` pulse while idle has no effect. The index, `busy_o` and `all_done_o` keep their values.
- R9: `start_i` takes priority over `pass_done_i` and also restarts a run in progress. The next cycle is busy at index 0 with `all_done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run at viewpoint 0 |
| pass_done_i | input | 1 | The current pass has finished |
| vp_idx_o | output | 4 | Current viewpoint index |
| busy_o | output | 1 | A run is in progress |
| all_done_o | output | 1 | The last pass has completed |
| src_sel_o | output | 2 | Frame select: 0 original, 1 full blur, 2 half width |
| bypass_o | output | 1 | Identity pass; feature stage fed directly |
| scaler_en_o | output | 1 | Scaler active for the pass |
| blur_wr_en_o | output | 1 | Write the full-blur frame |
| half_wr_en_o | output | 1 | Write the half-width frame |
| sx_o | output | 11 | Horizontal ratio code |
| sy_o | output | 11 | Vertical ratio code |
| eff_sx_o | output | 11 | Horizontal ratio applied to the selected frame |

## Verification
Two events can fall in the same cycle: a restart request and an end-of-pass pulse. The bench drives both on one edge mid-run and also while idle after completion, then checks that the index returns to 0 and not to the incremented value, and that the completion flag clears. A plain restart without a pass pulse is checked the same way. Each of the sixteen passes is swept and its select, ratios and enables are compared with values computed from the ratio list.

// File: rtl/vp_seq_pkg.sv
package vp_seq_pkg;
  localparam int FRAC_W = 10;
  localparam int SX_W   = FRAC_W + 1;
  localparam int ONE_Q  = 1 << FRAC_W;
  localparam int HALF_Q = 1 << (FRAC_W - 1);

  localparam logic [1:0] SRC_ORIG = 2'd0;
  localparam logic [1:0] SRC_FULL = 2'd1;
  localparam logic [1:0] SRC_HALF = 2'd2;
endpackage

// File: rtl/vp_pass_ctrl.sv
module vp_pass_ctrl #(
  parameter int NUM_VP = 16,
  localparam int IDX_W = $clog2(NUM_VP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pass_done_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             all_done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_VP - 1);

  logic [IDX_W-1:0] idx_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && pass_done_i) begin
      if (idx_q == LAST) begin
        idx_q  <= '0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idx_o      = idx_q;
  assign busy_o     = busy_q;
  assign all_done_o = done_q;
endmodule

// File: rtl/vp_ratio_rom.sv
module vp_ratio_rom
  import vp_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [SX_W-1:0]  sx_o,
  output logic [SX_W-1:0]  sy_o
);
  // codes carry FRAC_W fraction bits
  always_comb begin
    sx_o = SX_W'(ONE_Q);
    sy_o = SX_W'(ONE_Q);
    case (int'(idx_i))
      0:  begin sx_o = SX_W'(1024); sy_o = SX_W'(1024); end
      1:  begin sx_o = SX_W'(1024); sy_o = SX_W'(512);  end
      2:  begin sx_o = SX_W'(882);  sy_o = SX_W'(595);  end
      3:  begin sx_o = SX_W'(581);  sy_o = SX_W'(903);  end
      4:  begin sx_o = SX_W'(581);  sy_o = SX_W'(903);  end
      5:  begin sx_o = SX_W'(882);  sy_o = SX_W'(595);  end
      6:  begin sx_o = SX_W'(1024); sy_o = SX_W'(256);  end
      7:  begin sx_o = SX_W'(977);  sy_o = SX_W'(268);  end
      8:  begin sx_o = SX_W'(842);  sy_o = SX_W'(311);  end
      9:  begin sx_o = SX_W'(637);  sy_o = SX_W'(412);  end
      10: begin sx_o = SX_W'(399);  sy_o = SX_W'(655);  end
      11: begin sx_o = SX_W'(256);  sy_o = SX_W'(1024); end
      12: begin sx_o = SX_W'(399);  sy_o = SX_W'(656);  end
      13: begin sx_o = SX_W'(636);  sy_o = SX_W'(413);  end
      14: begin sx_o = SX_W'(842);  sy_o = SX_W'(311);  end
      15: begin sx_o = SX_W'(977);  sy_o = SX_W'(268);  end
      default: ;
    endcase
  end
endmodule

// File: rtl/vp_src_pick.sv
module vp_src_pick
  import vp_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             busy_i,
  input  logic [SX_W-1:0]  sx_i,
  output logic [1:0]       src_sel_o,
  output logic [SX_W-1:0]  eff_sx_o,
  output logic             bypass_o,
  output logic             scaler_en_o,
  output logic             blur_wr_o,
  output logic             half_wr_o
);
  logic first_pass;
  assign first_pass = busy_i && (idx_i == '0);

  assign bypass_o    = first_pass;
  assign blur_wr_o   = first_pass;
  assign half_wr_o   = first_pass;
  assign scaler_en_o = busy_i && (idx_i != '0);

  // ceil(2*sx)/2 == 1  <=>  sx strictly above one half
  always_comb begin
    if (!scaler_en_o)                 src_sel_o = SRC_ORIG;
    else if (sx_i > SX_W'(HALF_Q))    src_sel_o = SRC_FULL;
    else                              src_sel_o = SRC_HALF;
  end

  assign eff_sx_o = (src_sel_o == SRC_HALF) ? (sx_i << 1) : sx_i;
endmodule

// File: rtl/vp_src_seq.sv
module vp_src_seq
  import vp_seq_pkg::*;
#(
  parameter int NUM_VP = 16,
  localparam int IDX_W = $clog2(NUM_VP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pass_done_i,
  output logic [IDX_W-1:0] vp_idx_o,
  output logic             busy_o,
  output logic             all_done_o,
  output logic [1:0]       src_sel_o,
  output logic             bypass_o,
  output logic             scaler_en_o,
  output logic             blur_wr_en_o,
  output logic             half_wr_en_o,
  output logic [SX_W-1:0]  sx_o,
  output logic [SX_W-1:0]  sy_o,
  output logic [SX_W-1:0]  eff_sx_o
);
  vp_pass_ctrl #(.NUM_VP(NUM_VP)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pass_done_i (pass_done_i),
    .idx_o       (vp_idx_o),
    .busy_o      (busy_o),
    .all_done_o  (all_done_o)
  );

  vp_ratio_rom #(.IDX_W(IDX_W)) u_rom (
    .idx_i (vp_idx_o),
    .sx_o  (sx_o),
    .sy_o  (sy_o)
  );

  vp_src_pick #(.IDX_W(IDX_W)) u_pick (
    .idx_i       (vp_idx_o),
    .busy_i      (busy_o),
    .sx_i        (sx_o),
    .src_sel_o   (src_sel_o),
    .eff_sx_o    (eff_sx_o),
    .bypass_o    (bypass_o),
    .scaler_en_o (scaler_en_o),
    .blur_wr_o   (blur_wr_en_o),
    .half_wr_o   (half_wr_en_o)
  );
endmodule

// File: rtl/vp_src_seq_chk.sv
module vp_src_seq_chk
  import vp_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             pass_done_i,
  input logic [IDX_W-1:0] vp_idx_o,
  input logic             busy_o,
  input logic             all_done_o,
  input logic [1:0]       src_sel_o,
  input logic             scaler_en_o,
  input logic             blur_wr_en_o,
  input logic             half_wr_en_o,
  input logic [SX_W-1:0]  sx_o,
  input logic [SX_W-1:0]  eff_sx_o
);
  localparam logic [IDX_W-1:0] LAST = '1;

  // R2
  pass0_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blur_wr_en_o || half_wr_en_o) |-> (busy_o && vp_idx_o == '0 && !scaler_en_o));

  // R3
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pass_done_i && !start_i && vp_idx_o != LAST)
    |=> (busy_o && vp_idx_o == $past(vp_idx_o) + 1'b1));

  // R4
  half_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o == SRC_HALF) |-> (scaler_en_o && sx_o <= SX_W'(HALF_Q)));

  // R4
  full_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scaler_en_o && sx_o > SX_W'(HALF_Q)) |-> (src_sel_o == SRC_FULL));

  // R6
  eff_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o != SRC_HALF) |-> (eff_sx_o == sx_o));

  // R7
  run_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pass_done_i && !start_i && vp_idx_o == LAST)
    |=> (!busy_o && all_done_o && vp_idx_o == '0));

  // R8
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(vp_idx_o) && $stable(all_done_o)));

  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && vp_idx_o == '0 && !all_done_o));
endmodule

bind vp_src_seq vp_src_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .pass_done_i  (pass_done_i),
  .vp_idx_o     (vp_idx_o),
  .busy_o       (busy_o),
  .all_done_o   (all_done_o),
  .src_sel_o    (src_sel_o),
  .scaler_en_o  (scaler_en_o),
  .blur_wr_en_o (blur_wr_en_o),
  .half_wr_en_o (half_wr_en_o),
  .sx_o         (sx_o),
  .eff_sx_o     (eff_sx_o)
);

// File: tb/sim_vp_src_seq.sv
module sim_vp_src_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pdone = 1'b0;
  logic [3:0]  idx;
  logic        busy, adone, byp, sen, bwr, hwr;
  logic [1:0]  sel;
  logic [10:0] sx, sy, esx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vp_src_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pass_done_i(pdone),
    .vp_idx_o(idx), .busy_o(busy), .all_done_o(adone), .src_sel_o(sel),
    .bypass_o(byp), .scaler_en_o(sen), .blur_wr_en_o(bwr), .half_wr_en_o(hwr),
    .sx_o(sx), .sy_o(sy), .eff_sx_o(esx)
  );

  function automatic int exp_sx(int k);
    case (k)
      0, 1, 6: return 1024;
      2, 5:    return 882;
      3, 4:    return 581;
      7, 15:   return 977;
      8, 14:   return 842;
      9:       return 637;
      10, 12:  return 399;
      11:      return 256;
      13:      return 636;
      default: return 1024;
    endcase
  endfunction

  function automatic int exp_sy(int k);
    case (k)
      0, 11:   return 1024;
      1:       return 512;
      2, 5:    return 595;
      3, 4:    return 903;
      6:       return 256;
      7, 15:   return 268;
      8, 14:   return 311;
      9:       return 412;
      10:      return 655;
      12:      return 656;
      13:      return 413;
      default: return 1024;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive for one edge, sample at the following falling edge
  task automatic pulse(input bit s, input bit d);
    @(negedge clk);
    start = s;
    pdone = d;
    @(negedge clk);
    start = 1'b0;
    pdone = 1'b0;
  endtask

  task automatic check_pass(input int k);
    int es, ee, esel;
    es   = exp_sx(k);
    esel = (k == 0) ? 0 : ((es > 512) ? 1 : 2);
    ee   = (esel == 2) ? 2 * es : es;
    chk(idx == k[3:0], "R3 index", int'(idx), k);
    chk(busy == 1'b1, "R3 busy", int'(busy), 1);
    chk(int'(sx) == es, "R5 sx", int'(sx), es);
    chk(int'(sy) == exp_sy(k), "R5 sy", int'(sy), exp_sy(k));
    chk(int'(esx) == ee, "R6 eff_sx", int'(esx), ee);
    if (k == 0) begin
      chk(sel == 2'd0, "R2 src_sel", int'(sel), 0);
      chk(byp && bwr && hwr && !sen, "R2 enables", int'({byp, bwr, hwr, sen}), 4'b1110);
    end else begin
      chk(int'(sel) == esel, "R4 src_sel", int'(sel), esel);
      chk(!byp && !bwr && !hwr && sen, "R4 enables", int'({byp, bwr, hwr, sen}), 4'b0001);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(idx == 4'd0 && !busy && !adone, "R1 state", int'({idx, busy, adone}), 0);
    chk(!byp && !bwr && !hwr && !sen, "R1 enables", int'({byp, bwr, hwr, sen}), 0);
    rst_n = 1'b1;

    // R8 pass pulse while idle after reset
    pulse(1'b0, 1'b1);
    chk(idx == 4'd0 && !busy && !adone, "R8 idle pulse", int'({idx, busy, adone}), 0);

    // full sweep: R2 R3 R4 R5 R6
    pulse(1'b1, 1'b0);
    for (int k = 0; k < 16; k++) begin
      check_pass(k);
      if (k < 15) pulse(1'b0, 1'b1);
    end
    // R7 end of run
    pulse(1'b0, 1'b1);
    chk(!busy && adone && idx == 4'd0, "R7 end", int'({idx, busy, adone}), 1);
    chk(!sen && !bwr && !hwr && !byp, "R7 enables off", int'({byp, bwr, hwr, sen}), 0);
    repeat (4) @(negedge clk);
    chk(adone == 1'b1, "R7 sticky done", int'(adone), 1);

    // R8 pass pulse while idle after completion
    pulse(1'b0, 1'b1);
    chk(!busy && adone && idx == 4'd0, "R8 idle after done", int'({idx, busy, adone}), 1);

    // R9 start and pass pulse together while idle-done
    pulse(1'b1, 1'b1);
    chk(busy && !adone && idx == 4'd0, "R9 start wins idle", int'({idx, busy, adone}), 2);
    check_pass(0);

    // run to index 5, then collide
    for (int k = 0; k < 5; k++) pulse(1'b0, 1'b1);
    check_pass(5);
    pulse(1'b1, 1'b1);
    chk(busy && idx == 4'd0, "R9 start wins mid-run", int'(idx), 0);
    check_pass(0);

    // plain restart at index 11
    for (int k = 0; k < 11; k++) pulse(1'b0, 1'b1);
    check_pass(11);
    pulse(1'b1, 1'b0);
    chk(busy && !adone && idx == 4'd0, "R9 restart", int'({idx, busy, adone}), 2);

    // finish this run too and confirm done again
    for (int k = 0; k < 16; k++) pulse(1'b0, 1'b1);
    chk(!busy && adone, "R7 second run", int'({busy, adone}), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule